// File: doc/BRIEF.md
# Video Line and Frame Framing Tracker

This block watches a video pixel stream that has no sync or blanking signals, only a per-beat end-of-line flag and a per-beat start-of-frame flag. It counts the pixels accepted in the current line and the lines accepted in the current frame. These counts are compared against a programmed frame width and frame height. Explicit rules decide which beats enter the frame. A misplaced end-of-line is ignored. Pixels past the programmed width, and lines past the programmed height, are thrown away. A start-of-frame restarts the frame wherever it arrives.

The accepted beats pass straight through to the output stream, with no register in the path. The output carries regenerated markers: its end-of-line sits on the last pixel of each line, as the width defines it, and its start-of-frame sits on the first pixel of each frame. Rejected beats are still consumed from the source, so the source can never be stalled by them. The current pixel and line position are exposed for downstream use.

Top module: `vid_frame_tracker`

## Requirements
- R1: After reset, pix_pos and line_pos read 0, and every beat without the input start-of-frame flag is dropped (m_valid stays low) until a start-of-frame beat arrives.
- R2: A beat with s_sof is always accepted. The output shows it with m_sof high. It loads cfg_width and cfg_height for the new frame, and a programmed value of 0 is used as 1.
- R3: The accepted pixel at index width-1 of a line carries m_eol. If that beat also has s_eol, then from the next cycle pix_pos reads 0 and line_pos has advanced by one.
- R4: An s_eol on a beat whose pixel index is below width-1 is ignored. The beat is accepted without m_eol, and pix_pos keeps counting.
- R5: Once width pixels are accepted without s_eol, pix_pos holds at the width. All following beats are then dropped, including the beat that carries s_eol. From the cycle after that s_eol beat, pix_pos reads 0.
- R6: An s_sof in the middle of a frame or line restarts the frame. That beat becomes pixel 0 of line 0 with m_sof, so afterwards pix_pos reads 1 and line_pos reads 0 (for width above 1).
- R7: When the line count reaches the height, line_pos returns to 0. Every beat without s_sof is then dropped until a start-of-frame beat arrives.
- R8: s_ready equals m_ready. While m_ready is low, no beat is consumed and pix_pos and line_pos do not change.
- R9: Accepted beats appear on the output in the same cycle, in order, with m_data equal to s_data. Dropped beats never appear on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | DIM_W | Pixels per line, sampled at start-of-frame |
| cfg_height | input | DIM_W | Lines per frame, sampled at start-of-frame |
| s_data | input | DATA_W | Input pixel |
| s_valid | input | 1 | Input beat valid |
| s_eol | input | 1 | Input end-of-line flag |
| s_sof | input | 1 | Input start-of-frame flag |
| s_ready | output | 1 | Input ready, follows m_ready |
| m_data | output | DATA_W | Output pixel |
| m_valid | output | 1 | Output beat valid, accepted beats only |
| m_eol | output | 1 | Regenerated end-of-line |
| m_sof | output | 1 | Regenerated start-of-frame |
| m_ready | input | 1 | Output ready from downstream |
| pix_pos | output | DIM_W | Index of the next pixel in the current line |
| line_pos | output | DIM_W | Index of the current line in the frame |

## Verification
The assertions take the flags to be meaningful only on beats where valid and ready are both high. They also expect the sampled width and height never to be exceeded, because a new frame can only reload them on a start-of-frame. Stall checks assume the downstream ready is the only thing that holds a beat back. The stimulus keeps cfg_width and cfg_height fixed within a frame, changing them only before a start-of-frame beat. It drives the flags only together with valid, and lowers ready only on a beat that must not advance the counters.

// File: rtl/vid_frame_tracker.sv
module vid_frame_tracker #(
  parameter int DATA_W = 24,
  parameter int DIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_eol,
  input  logic              s_sof,
  output logic              s_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_valid,
  output logic              m_eol,
  output logic              m_sof,
  input  logic              m_ready,
  output logic [DIM_W-1:0]  pix_pos,
  output logic [DIM_W-1:0]  line_pos
);

  typedef enum logic [1:0] {M_SEEK, M_RUN, M_HOLD} mode_t;
  localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

  mode_t            mode;
  logic [DIM_W-1:0] pix_cnt, line_cnt, wid_q, hgt_q;
  logic [DIM_W-1:0] wid_eff, hgt_eff, pix_here, line_here, pix_next, line_next;
  logic             fire, accept, line_full, frame_done;

  assign fire       = s_valid & m_ready;
  assign wid_eff    = s_sof ? ((cfg_width  == '0) ? ONE : cfg_width)  : wid_q;
  assign hgt_eff    = s_sof ? ((cfg_height == '0) ? ONE : cfg_height) : hgt_q;
  assign pix_here   = s_sof ? '0 : pix_cnt;
  assign line_here  = s_sof ? '0 : line_cnt;
  assign pix_next   = pix_here + ONE;
  assign line_next  = line_here + ONE;
  assign line_full  = (pix_next == wid_eff);
  assign frame_done = (line_next == hgt_eff);
  assign accept     = s_valid & (s_sof | (mode == M_RUN));

  assign s_ready  = m_ready;
  assign m_data   = s_data;
  assign m_valid  = accept;
  assign m_sof    = accept & s_sof;
  assign m_eol    = accept & line_full;
  assign pix_pos  = pix_cnt;
  assign line_pos = line_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= M_SEEK;
      pix_cnt  <= '0;
      line_cnt <= '0;
      wid_q    <= ONE;
      hgt_q    <= ONE;
    end else if (fire) begin
      if (s_sof) begin
        wid_q <= wid_eff;
        hgt_q <= hgt_eff;
      end
      if ((accept && line_full && s_eol) || (!accept && mode == M_HOLD && s_eol)) begin
        pix_cnt <= '0;
        if (frame_done) begin
          line_cnt <= '0;
          mode     <= M_SEEK;
        end else begin
          line_cnt <= line_next;
          mode     <= M_RUN;
        end
      end else if (accept) begin
        pix_cnt  <= pix_next;
        line_cnt <= line_here;
        mode     <= line_full ? M_HOLD : M_RUN;
      end
    end
  end

  assert_seek_drop_R1: assert property (@(posedge clk) disable iff (rst)
    (mode == M_SEEK && s_valid && !s_sof) |-> !m_valid);

  assert_pix_bound_R4: assert property (@(posedge clk) disable iff (rst)
    pix_cnt <= wid_q);

  assert_eol_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (fire && mode == M_HOLD && !s_sof && s_eol) |=> (pix_cnt == '0));

  assert_sof_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (fire && s_sof && cfg_width > ONE) |=> (pix_cnt == ONE && line_cnt == '0));

  assert_line_bound_R7: assert property (@(posedge clk) disable iff (rst)
    line_cnt < hgt_q);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !m_ready |=> ($stable(pix_cnt) && $stable(line_cnt)));

endmodule

// File: tb/vid_frame_tracker_bench.sv
`timescale 1ns/1ps
module vid_frame_tracker_bench;
  localparam int DW = 24;
  localparam int NW = 16;

  logic clk = 0, rst = 1;
  logic [NW-1:0] cfg_width = 4, cfg_height = 2;
  logic [DW-1:0] s_data = '0;
  logic s_valid = 0, s_eol = 0, s_sof = 0, m_ready = 1;
  logic s_ready, m_valid, m_eol, m_sof;
  logic [DW-1:0] m_data;
  logic [NW-1:0] pix_pos, line_pos;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW+1:0] exp_q[$];
  string         req_q[$];

  always #4 clk = ~clk;

  vid_frame_tracker #(.DATA_W(DW), .DIM_W(NW)) u_vid_frame_tracker (
    .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .s_data(s_data), .s_valid(s_valid), .s_eol(s_eol), .s_sof(s_sof), .s_ready(s_ready),
    .m_data(m_data), .m_valid(m_valid), .m_eol(m_eol), .m_sof(m_sof), .m_ready(m_ready),
    .pix_pos(pix_pos), .line_pos(line_pos));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #2;
    if (m_valid && m_ready) begin
      if (exp_q.size() == 0)
        chk(0, "R9 unexpected output beat", {m_data, m_eol, m_sof}, 0);
      else begin
        logic [DW+1:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk({m_data, m_eol, m_sof} == e, {r, "/R9 output beat"}, {m_data, m_eol, m_sof}, e);
      end
    end
  end

  task automatic send(input logic [DW-1:0] d, input bit eol, input bit sof,
                      input bit acc, input bit xeol, input bit xsof, input string req);
    @(negedge clk);
    s_data = d; s_eol = eol; s_sof = sof; s_valid = 1;
    if (acc) begin
      exp_q.push_back({d, xeol, xsof});
      req_q.push_back(req);
    end
    #1;
    chk(m_valid == acc, {req, " accept"}, m_valid, acc);
  endtask

  task automatic check_pos(input logic [NW-1:0] px, input logic [NW-1:0] ln, input string req);
    @(negedge clk);
    s_valid = 0; s_eol = 0; s_sof = 0;
    #1;
    chk(pix_pos == px, {req, " pix_pos"}, pix_pos, px);
    chk(line_pos == ln, {req, " line_pos"}, line_pos, ln);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check_pos(0, 0, "R1 reset");
    send(24'h01, 0, 0, 0, 0, 0, "R1");
    check_pos(0, 0, "R1");
    // frame 1, width 4, height 2
    send(24'h02, 0, 1, 1, 0, 1, "R2");
    send(24'h03, 0, 0, 1, 0, 0, "R4");
    send(24'h04, 1, 0, 1, 0, 0, "R4");
    check_pos(3, 0, "R4");
    send(24'h05, 1, 0, 1, 1, 0, "R3");
    check_pos(0, 1, "R3");
    send(24'h06, 0, 0, 1, 0, 0, "R3");
    send(24'h07, 0, 0, 1, 0, 0, "R3");
    send(24'h08, 0, 0, 1, 0, 0, "R3");
    send(24'h09, 0, 0, 1, 1, 0, "R5");
    check_pos(4, 1, "R5");
    send(24'h0A, 0, 0, 0, 0, 0, "R5");
    send(24'h0B, 1, 0, 0, 0, 0, "R5");
    check_pos(0, 0, "R7");
    send(24'h0C, 1, 0, 0, 0, 0, "R7");
    send(24'h0D, 0, 0, 0, 0, 0, "R7");
    // frame 2 with early restart
    send(24'h0E, 0, 1, 1, 0, 1, "R6");
    send(24'h0F, 0, 0, 1, 0, 0, "R6");
    send(24'h10, 0, 1, 1, 0, 1, "R6");
    check_pos(1, 0, "R6");
    // stall
    @(negedge clk);
    m_ready = 0; s_valid = 1; s_data = 24'h11; s_eol = 1; s_sof = 0;
    #1;
    chk(s_ready == 0, "R8 s_ready", s_ready, 0);
    check_pos(1, 0, "R8");
    m_ready = 1;
    // zero width and height read as one
    cfg_width = 0; cfg_height = 0;
    send(24'h20, 1, 1, 1, 1, 1, "R2");
    check_pos(0, 0, "R2");
    send(24'h21, 0, 0, 0, 0, 0, "R2");
    send(24'h22, 0, 1, 1, 1, 1, "R2");
    check_pos(1, 0, "R5");
    send(24'h23, 1, 0, 0, 0, 0, "R5");
    check_pos(0, 0, "R7");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 pending beats", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule